// File: doc/BRIEF.md
# Mixed-Grain Reconfigurable Compute Cell

This block is a single processing element of a reconfigurable compute array. A latched 32-bit context word sets what it does. The context word chooses two operand sources, an ALU operation and a destination register. It can also send either operand through a small lookup table before the ALU sees it. The ALU works on 32-bit operands and produces a 64-bit result. A 15-entry local register bank stores results. Registers 13 and 14 are also driven straight out to the self-DMA and self-reconfiguration controllers that sit next to the cell.

Work enters as a stream of operation beats. Each accepted beat carries one data-buffer word and runs the current context once. Every accepted beat produces one result beat on a valid/ready output. The result beat carries two holding registers: the low result word, and the high word of the most recent multiply. The output holds one beat. While that beat is not taken (`res_valid` high, `res_ready` low), `op_ready` is low and no new operation runs. The beat stays unchanged until the downstream side takes it. A host loads the two 256 x 16 lookup tables through a separate write port. The context word never writes them.

Top module: `rc_cell`

Context word layout:
- bits [1:0]: class
- bits [5:2]: sub-code
- bits [9:6]: destination
- bits [15:10]: source A
- bits [21:16]: source B
- bit 22: table A routing
- bit 23: table B routing
- bits [31:24]: ignored

## Requirements
- R1: After reset, `res_valid` is 0 and `op_ready` is 1. Both self-unit register outputs and every register read 0. The active context is idle: class 2, sub-code 2.
- R2: Class 0 is logic. Sub-code 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives NOT A. The 32-bit value goes to the destination register and to `res_lo`.
- R3: Class 1 with sub-code 0 (ADD) or 1 (SUB) writes the low 32 bits of A+B or A-B, wrapping modulo 2^32, to the destination and `res_lo`. `res_hi` is unchanged.
- R4: Class 1 with sub-code 2 (MUL) forms the unsigned 64-bit product. The low 32 bits go to the destination and `res_lo`. The high 32 bits go to `res_hi`.
- R5: The following write no register and leave `res_lo`/`res_hi` unchanged: class 2 sub-code 2 (KEEP), class 3, and any sub-code not listed. Each still emits a result beat. Class 2 sub-code 0 (BYP) writes operand A unchanged.
- R6: Class 2 sub-code 1 clears all 15 registers and both holding registers. The beat it emits is zero.
- R7: Source selector bits [5:4] pick the source class and bits [3:0] the index. Class 0 gives local register 0..14, and index 15 gives `buf_data`. Class 1 is a row bus, class 2 a column bus and class 3 a nearby bus. A bus index at or beyond the bus count reads 0. Operands are read before the write of the same operation.
- R8: When context bit 22 (23) is set, operand A (B) is replaced by the zero-extended 16-bit table A (B) entry at its own low 8 bits. A table write (`lut_sel` 0 = A, 1 = B) takes effect for operations from the next cycle.
- R9: A context presented with `ctx_load` governs operations accepted from the next clock edge. An operation accepted in the same cycle uses the previous context.
- R10: `op_ready` equals NOT `res_valid` OR `res_ready`. An accepted beat makes `res_valid` 1 on the next edge. A beat left untaken holds `res_lo`/`res_hi` stable.
- R11: `self_dma_reg` always shows register 13 and `self_ctx_reg` shows register 14.
- R12: Destination 15 stores into no register, but the result still updates `res_lo` and the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Latch `ctx_word` as the new context |
| ctx_word | input | 32 | Context word |
| lut_we | input | 1 | Lookup table write strobe |
| lut_sel | input | 1 | Table chosen for the write (0 = A, 1 = B) |
| lut_addr | input | 8 | Table write address |
| lut_wdata | input | 16 | Table write data |
| op_valid | input | 1 | Operation beat offered |
| op_ready | output | 1 | Operation beat can be accepted |
| buf_data | input | 32 | Data-buffer word carried by the operation beat |
| row_bus | input | ROW_N*32 | Row neighbour buses, bus i at bits [32i+31:32i] |
| col_bus | input | COL_N*32 | Column neighbour buses |
| nbr_bus | input | NBR_N*32 | Nearby-cell buses |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Downstream takes the result beat |
| res_lo | output | 32 | Low result holding register |
| res_hi | output | 32 | Multiply high-word holding register |
| self_dma_reg | output | 32 | Register 13, to the self-DMA unit |
| self_ctx_reg | output | 32 | Register 14, to the self-reconfiguration unit |

## Verification
The bench builds the cell with its defaults: 8 row buses, 8 column buses and 16 nearby buses. With 8-entry row and column bus sets, selector indices 8 to 15 go past the bus count, so the zero read for out-of-range buses can be checked. With 16 nearby buses, every nearby index is a real bus. Both tables are filled completely first. After that, a random stretch of context loads, table rewrites and stalled outputs can route any operand through either table and be predicted exactly by the reference model.

// File: rtl/rc_cell_pkg.sv
`timescale 1ns/1ps
package rc_cell_pkg;
  localparam int DW     = 32;
  localparam int RIDX_W = 4;
  localparam int SEL_W  = 6;
  localparam int LUT_IW = 8;
  localparam int LUT_OW = 16;

  typedef enum logic [1:0] {
    OPC_LOGIC = 2'd0,
    OPC_ARITH = 2'd1,
    OPC_MISC  = 2'd2,
    OPC_SPARE = 2'd3
  } opc_e;

  localparam logic [3:0] SUB_AND  = 4'd0;
  localparam logic [3:0] SUB_OR   = 4'd1;
  localparam logic [3:0] SUB_XOR  = 4'd2;
  localparam logic [3:0] SUB_NOT  = 4'd3;
  localparam logic [3:0] SUB_ADD  = 4'd0;
  localparam logic [3:0] SUB_SUB  = 4'd1;
  localparam logic [3:0] SUB_MUL  = 4'd2;
  localparam logic [3:0] SUB_BYP  = 4'd0;
  localparam logic [3:0] SUB_RST  = 4'd1;
  localparam logic [3:0] SUB_KEEP = 4'd2;

  localparam logic [1:0] SRC_LOCAL = 2'd0;
  localparam logic [1:0] SRC_ROW   = 2'd1;
  localparam logic [1:0] SRC_COL   = 2'd2;
  localparam logic [1:0] SRC_NEAR  = 2'd3;

  typedef struct packed {
    logic [7:0]        spare;
    logic              lut_b;
    logic              lut_a;
    logic [SEL_W-1:0]  sel_b;
    logic [SEL_W-1:0]  sel_a;
    logic [RIDX_W-1:0] dst;
    logic [3:0]        sub;
    opc_e              op;
  } ctx_t;

  localparam logic [31:0] CTX_IDLE = 32'h0000_000A;
endpackage

// File: rtl/rc_alu.sv
`timescale 1ns/1ps
module rc_alu
  import rc_cell_pkg::*;
(
  input  opc_e            op,
  input  logic [3:0]      sub,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] res,
  output logic            wr,
  output logic            wr_hi,
  output logic            clr
);
  localparam logic [DW-1:0] ZW = '0;

  always_comb begin
    res   = '0;
    wr    = 1'b0;
    wr_hi = 1'b0;
    clr   = 1'b0;
    case (op)
      OPC_LOGIC: begin
        wr = 1'b1;
        case (sub)
          SUB_AND: res = {ZW, a & b};
          SUB_OR:  res = {ZW, a | b};
          SUB_XOR: res = {ZW, a ^ b};
          SUB_NOT: res = {ZW, ~a};
          default: wr = 1'b0;
        endcase
      end
      OPC_ARITH: begin
        wr = 1'b1;
        case (sub)
          SUB_ADD: res = {ZW, a} + {ZW, b};
          SUB_SUB: res = {ZW, a} - {ZW, b};
          SUB_MUL: begin
            res   = {ZW, a} * {ZW, b};
            wr_hi = 1'b1;
          end
          default: wr = 1'b0;
        endcase
      end
      OPC_MISC: begin
        case (sub)
          SUB_BYP: begin
            res = {ZW, a};
            wr  = 1'b1;
          end
          SUB_RST: clr = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rc_regbank.sv
`timescale 1ns/1ps
module rc_regbank #(
  parameter int DW      = 32,
  parameter int NREG    = 15,
  parameter int AW      = 4,
  parameter int DMA_IDX = 13,
  parameter int CTX_IDX = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdat,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdat_a,
  output logic [DW-1:0] rdat_b,
  output logic [DW-1:0] q_dma,
  output logic [DW-1:0] q_ctx
);
  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we && int'(widx) < NREG) begin
      rf[widx] <= wdat;
    end
  end

  assign rdat_a = (int'(raddr_a) < NREG) ? rf[raddr_a] : '0;
  assign rdat_b = (int'(raddr_b) < NREG) ? rf[raddr_b] : '0;
  assign q_dma  = rf[DMA_IDX];
  assign q_ctx  = rf[CTX_IDX];

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_dma == '0 && q_ctx == '0));
  assert_dma_tap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr && int'(widx) == DMA_IDX) |=> q_dma == $past(wdat));
  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> ($stable(q_dma) && $stable(q_ctx)));
endmodule

// File: rtl/rc_opnd_sel.sv
`timescale 1ns/1ps
module rc_opnd_sel #(
  parameter int DW    = 32,
  parameter int ROW_N = 8,
  parameter int COL_N = 8,
  parameter int NBR_N = 16
) (
  input  logic [5:0]          sel,
  input  logic [DW-1:0]       rf_dat,
  input  logic [DW-1:0]       buf_dat,
  input  logic [ROW_N*DW-1:0] row_bus,
  input  logic [COL_N*DW-1:0] col_bus,
  input  logic [NBR_N*DW-1:0] nbr_bus,
  output logic [DW-1:0]       opnd
);
  import rc_cell_pkg::SRC_LOCAL;
  import rc_cell_pkg::SRC_ROW;
  import rc_cell_pkg::SRC_COL;

  logic [3:0] idx;
  assign idx = sel[3:0];

  always_comb begin
    opnd = '0;
    case (sel[5:4])
      SRC_LOCAL: opnd = (idx == 4'hF) ? buf_dat : rf_dat;
      SRC_ROW: begin
        for (int i = 0; i < ROW_N; i++)
          if (int'(idx) == i) opnd = row_bus[i*DW +: DW];
      end
      SRC_COL: begin
        for (int i = 0; i < COL_N; i++)
          if (int'(idx) == i) opnd = col_bus[i*DW +: DW];
      end
      default: begin
        for (int i = 0; i < NBR_N; i++)
          if (int'(idx) == i) opnd = nbr_bus[i*DW +: DW];
      end
    endcase
  end
endmodule

// File: rtl/rc_lut.sv
`timescale 1ns/1ps
module rc_lut #(
  parameter int IW = 8,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [OW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [OW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;
  logic [OW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  assert_lut_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rc_cell.sv
`timescale 1ns/1ps
module rc_cell
  import rc_cell_pkg::*;
#(
  parameter int ROW_N = 8,
  parameter int COL_N = 8,
  parameter int NBR_N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctx_load,
  input  logic [31:0]         ctx_word,
  input  logic                lut_we,
  input  logic                lut_sel,
  input  logic [LUT_IW-1:0]   lut_addr,
  input  logic [LUT_OW-1:0]   lut_wdata,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [DW-1:0]       buf_data,
  input  logic [ROW_N*DW-1:0] row_bus,
  input  logic [COL_N*DW-1:0] col_bus,
  input  logic [NBR_N*DW-1:0] nbr_bus,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [DW-1:0]       res_lo,
  output logic [DW-1:0]       res_hi,
  output logic [DW-1:0]       self_dma_reg,
  output logic [DW-1:0]       self_ctx_reg
);
  localparam int NREG   = 15;
  localparam int NLUT   = 2;
  localparam logic [RIDX_W-1:0] NO_DST = '1;

  ctx_t              ctx_q;
  logic              fire;
  logic [DW-1:0]     rf_a, rf_b;
  logic [DW-1:0]     raw [NLUT];
  logic [LUT_OW-1:0] lut_q [NLUT];
  logic [DW-1:0]     opnd [NLUT];
  logic [NLUT-1:0]   route;
  logic [2*DW-1:0]   alu_res;
  logic              alu_wr, alu_wr_hi, alu_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctx_q <= ctx_t'(CTX_IDLE);
    else if (ctx_load) ctx_q <= ctx_t'(ctx_word);
  end

  assign op_ready = !res_valid || res_ready;
  assign fire     = op_valid && op_ready;
  assign route    = {ctx_q.lut_b, ctx_q.lut_a};

  rc_regbank #(.DW(DW), .NREG(NREG), .AW(RIDX_W), .DMA_IDX(13), .CTX_IDX(14)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fire && alu_clr),
    .we      (fire && alu_wr && ctx_q.dst != NO_DST),
    .widx    (ctx_q.dst),
    .wdat    (alu_res[DW-1:0]),
    .raddr_a (ctx_q.sel_a[RIDX_W-1:0]),
    .raddr_b (ctx_q.sel_b[RIDX_W-1:0]),
    .rdat_a  (rf_a),
    .rdat_b  (rf_b),
    .q_dma   (self_dma_reg),
    .q_ctx   (self_ctx_reg)
  );

  rc_opnd_sel #(.DW(DW), .ROW_N(ROW_N), .COL_N(COL_N), .NBR_N(NBR_N)) u_sel_a (
    .sel (ctx_q.sel_a), .rf_dat (rf_a), .buf_dat (buf_data),
    .row_bus (row_bus), .col_bus (col_bus), .nbr_bus (nbr_bus), .opnd (raw[0])
  );

  rc_opnd_sel #(.DW(DW), .ROW_N(ROW_N), .COL_N(COL_N), .NBR_N(NBR_N)) u_sel_b (
    .sel (ctx_q.sel_b), .rf_dat (rf_b), .buf_dat (buf_data),
    .row_bus (row_bus), .col_bus (col_bus), .nbr_bus (nbr_bus), .opnd (raw[1])
  );

  for (genvar g = 0; g < NLUT; g++) begin : g_lut
    rc_lut #(.IW(LUT_IW), .OW(LUT_OW)) u_lut (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lut_we && (int'(lut_sel) == g)),
      .waddr (lut_addr),
      .wdata (lut_wdata),
      .raddr (raw[g][LUT_IW-1:0]),
      .rdata (lut_q[g])
    );
    assign opnd[g] = route[g] ? {{(DW-LUT_OW){1'b0}}, lut_q[g]} : raw[g];
  end

  rc_alu u_alu (
    .op (ctx_q.op), .sub (ctx_q.sub), .a (opnd[0]), .b (opnd[1]),
    .res (alu_res), .wr (alu_wr), .wr_hi (alu_wr_hi), .clr (alu_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      if (fire) begin
        res_valid <= 1'b1;
        if (alu_clr) begin
          res_lo <= '0;
          res_hi <= '0;
        end else begin
          if (alu_wr)    res_lo <= alu_res[DW-1:0];
          if (alu_wr_hi) res_hi <= alu_res[2*DW-1:DW];
        end
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assert_beat_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_lo) && $stable(res_hi)));
  assert_accept_emits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> res_valid);
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);
endmodule

// File: tb/rc_cell_test.sv
`timescale 1ns/1ps
module rc_cell_test;
  localparam int ROW_N = 8, COL_N = 8, NBR_N = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ctx_load = 0; logic [31:0] ctx_word = 0;
  logic lut_we = 0, lut_sel = 0; logic [7:0] lut_addr = 0; logic [15:0] lut_wdata = 0;
  logic op_valid = 0, op_ready; logic [31:0] buf_data = 0;
  logic [ROW_N*32-1:0] row_bus; logic [COL_N*32-1:0] col_bus; logic [NBR_N*32-1:0] nbr_bus;
  logic res_valid, res_ready = 1;
  logic [31:0] res_lo, res_hi, self_dma_reg, self_ctx_reg;

  rc_cell #(.ROW_N(ROW_N), .COL_N(COL_N), .NBR_N(NBR_N)) uut (.*);

  int checks = 0, errors = 0;
  string cur_req = "R1";

  logic [31:0] m_rf [15];
  logic [31:0] m_ctx, m_lo, m_hi;
  bit m_v;
  logic [15:0] m_lut [2][256];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pick(logic [5:0] s);
    int k = int'(s[3:0]);
    case (s[5:4])
      2'd0: return (k == 15) ? buf_data : m_rf[k];
      2'd1: return (k < ROW_N) ? row_bus[k*32 +: 32] : 32'h0;
      2'd2: return (k < COL_N) ? col_bus[k*32 +: 32] : 32'h0;
      default: return (k < NBR_N) ? nbr_bus[k*32 +: 32] : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mk(int op, int sub, int dst, int sa, int sb, bit la, bit lb);
    return {8'h0, lb, la, 6'(sb), 6'(sa), 4'(dst), 4'(sub), 2'(op)};
  endfunction

  // Reference model: steps at each rising edge, compared a quarter period later
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) m_rf[i] = 0;
      m_ctx = 32'h0000_000A; m_lo = 0; m_hi = 0; m_v = 0;
    end else begin
      bit rdy, fire;
      rdy  = !m_v || res_ready;
      fire = op_valid && rdy;
      if (fire) begin
        logic [31:0] a, b, lo; logic [63:0] p;
        int op, sub, dst; bit wr, clr;
        op = int'(m_ctx[1:0]); sub = int'(m_ctx[5:2]); dst = int'(m_ctx[9:6]);
        a = pick(m_ctx[15:10]); b = pick(m_ctx[21:16]);
        if (m_ctx[22]) a = {16'h0, m_lut[0][a[7:0]]};
        if (m_ctx[23]) b = {16'h0, m_lut[1][b[7:0]]};
        wr = 0; clr = 0; lo = 0;
        if (op == 0 && sub <= 3) begin
          wr = 1;
          lo = (sub == 0) ? (a & b) : (sub == 1) ? (a | b) : (sub == 2) ? (a ^ b) : ~a;
        end else if (op == 1 && sub <= 2) begin
          wr = 1;
          if (sub == 0) lo = a + b;
          else if (sub == 1) lo = a - b;
          else begin p = 64'(a) * 64'(b); lo = p[31:0]; m_hi = p[63:32]; end
        end else if (op == 2 && sub == 0) begin wr = 1; lo = a; end
        else if (op == 2 && sub == 1) clr = 1;
        if (clr) begin
          for (int i = 0; i < 15; i++) m_rf[i] = 0;
          m_lo = 0; m_hi = 0;
        end else if (wr) begin
          m_lo = lo;
          if (dst < 15) m_rf[dst] = lo;
        end
        m_v = 1;
      end else if (res_ready) m_v = 0;
      if (lut_we) m_lut[lut_sel][lut_addr] = lut_wdata;
      if (ctx_load) m_ctx = ctx_word;
    end
    #5;
    if (rst_n) begin
      chk(cur_req, "res_valid", 32'(res_valid), 32'(m_v));
      chk(cur_req, "op_ready", 32'(op_ready), 32'(!m_v || res_ready));
      if (m_v) begin
        chk(cur_req, "res_lo", res_lo, m_lo);
        chk(cur_req, "res_hi", res_hi, m_hi);
      end
      chk("R11", "self_dma_reg", self_dma_reg, m_rf[13]);
      chk("R11", "self_ctx_reg", self_ctx_reg, m_rf[14]);
    end
  end

  task automatic issue(logic [31:0] ctx, logic [31:0] b, string req);
    @(negedge clk); cur_req = req; ctx_load = 1; ctx_word = ctx; op_valid = 0;
    @(negedge clk); ctx_load = 0; op_valid = 1; buf_data = b;
    @(negedge clk); op_valid = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ROW_N; i++) row_bus[i*32 +: 32] = 32'h1100_0000 + 32'(i * 3);
    for (int i = 0; i < COL_N; i++) col_bus[i*32 +: 32] = 32'h2200_0000 + 32'(i * 5);
    for (int i = 0; i < NBR_N; i++) nbr_bus[i*32 +: 32] = 32'h3300_0000 + 32'(i * 7);
    for (int i = 0; i < 2; i++) for (int j = 0; j < 256; j++) m_lut[i][j] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", 32'(res_valid), 0);
    chk("R1", "op_ready", 32'(op_ready), 1);
    chk("R1", "self_dma_reg", self_dma_reg, 0);
    chk("R1", "self_ctx_reg", self_ctx_reg, 0);
    rst_n = 1;
    @(negedge clk);
    // R8: fill both tables
    cur_req = "R8";
    for (int s = 0; s < 2; s++)
      for (int j = 0; j < 256; j++) begin
        lut_we = 1; lut_sel = s[0]; lut_addr = 8'(j);
        lut_wdata = 16'(j * 40503 + s * 7919);
        @(negedge clk);
      end
    lut_we = 0;
    // R7, R11: load every register through the buffer with BYP (R5)
    for (int i = 0; i < 15; i++) issue(mk(2, 0, i, 15, 0, 0, 0), 32'hA5A5_0000 + 32'(i * 257), "R7");
    chk("R11", "dma tap value", self_dma_reg, 32'hA5A5_0000 + 32'(13 * 257));
    // R2 logic ops across source classes
    issue(mk(0, 0, 1, 2, 3, 0, 0), 0, "R2");
    issue(mk(0, 1, 2, 16 + 3, 32 + 4, 0, 0), 0, "R2");
    issue(mk(0, 2, 3, 48 + 9, 15, 0, 0), 32'hFFFF_0F0F, "R2");
    issue(mk(0, 3, 4, 5, 0, 0, 0), 0, "R2");
    // R7: out-of-range bus index reads zero
    issue(mk(0, 1, 5, 16 + 12, 32 + 9, 0, 0), 0, "R7");
    chk("R7", "out of range bus", res_lo, 32'h0);
    // R3 wraparound
    issue(mk(2, 0, 6, 15, 0, 0, 0), 32'hFFFF_FFFF, "R3");
    issue(mk(1, 0, 7, 6, 15, 0, 0), 32'h0000_0002, "R3");
    chk("R3", "add wrap", res_lo, 32'h1);
    issue(mk(1, 1, 8, 15, 6, 0, 0), 32'h0000_0000, "R3");
    // R4 multiply
    issue(mk(1, 2, 9, 6, 6, 0, 0), 0, "R4");
    chk("R4", "mul low", res_lo, 32'h0000_0001);
    chk("R4", "mul high", res_hi, 32'hFFFF_FFFE);
    issue(mk(1, 2, 10, 15, 16 + 1, 0, 0), 32'h1234_5678, "R4");
    // R5: KEEP, spare class, undefined sub-codes
    issue(mk(2, 2, 0, 15, 0, 0, 0), 32'hDEAD_BEEF, "R5");
    issue(mk(3, 0, 0, 15, 0, 0, 0), 32'hDEAD_BEEF, "R5");
    issue(mk(0, 9, 0, 15, 0, 0, 0), 32'hDEAD_BEEF, "R5");
    issue(mk(1, 7, 0, 15, 0, 0, 0), 32'hDEAD_BEEF, "R5");
    // R12: destination 15 discards
    issue(mk(2, 0, 15, 15, 0, 0, 0), 32'h5555_AAAA, "R12");
    chk("R12", "discarded result streamed", res_lo, 32'h5555_AAAA);
    // R8: table routing
    issue(mk(1, 0, 11, 15, 48 + 2, 1, 1), 32'h0000_0077, "R8");
    // R9: context load in the same cycle as an operation
    @(negedge clk); cur_req = "R9"; ctx_load = 1; ctx_word = mk(2, 0, 12, 15, 0, 0, 0);
    @(negedge clk); ctx_word = mk(0, 3, 12, 15, 0, 0, 0); op_valid = 1; buf_data = 32'h0F0F_0F0F;
    @(negedge clk); ctx_load = 0;
    chk("R9", "old context used", res_lo, 32'h0F0F_0F0F);
    @(negedge clk); op_valid = 0;
    chk("R9", "new context used", res_lo, 32'hF0F0_F0F0);
    // R6 clear
    issue(mk(2, 1, 0, 0, 0, 0, 0), 0, "R6");
    chk("R6", "clear lo", res_lo, 0);
    chk("R6", "clear hi", res_hi, 0);
    chk("R6", "clear r14", self_ctx_reg, 0);
    // R10: random traffic with back-pressure
    cur_req = "R10";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      op_valid  = $urandom % 2 == 0;
      res_ready = $urandom % 4 != 0;
      ctx_load  = $urandom % 5 == 0;
      ctx_word  = $urandom;
      buf_data  = $urandom;
      lut_we    = $urandom % 8 == 0;
      lut_sel   = 1'($urandom);
      lut_addr  = 8'($urandom);
      lut_wdata = 16'($urandom);
    end
    @(negedge clk);
    op_valid = 0; ctx_load = 0; lut_we = 0; res_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule